// File: doc/BRIEF.md
# Out-of-Order Operand-Capture Issue Pool

This block is a shared pool of scheduling slots that sits between the in-order dispatch stage and a set of execution ports. Each dispatched micro-operation takes one slot. A slot stores the operation code, the target port number, a destination tag, and two source operands. Each source holds either its value or the tag of the result it is still waiting for.

Result buses broadcast a tag and a value. Any waiting source whose tag matches takes the value. Every cycle, each port independently picks the lowest-numbered slot that has both operands and targets that port, provided the port is free. It then sends that slot's contents out on registered issue outputs. Slots leave in any order, not in arrival order. A flush empties the pool.

Top module: `rs_pool`

## Requirements
- R1: After reset, and on the edge that samples `flush` high, every slot is emptied, `disp_ready` reads 1 and all `iss_valid` bits read 0 on the following cycle.
- R2: A dispatch (`disp_valid` high while `disp_ready` is high) is written into the lowest-numbered empty slot. `disp_ready` is low exactly when all ENTRIES slots are occupied, and a dispatch offered while it is low is dropped without effect.
- R3: A source dispatched with its ready bit at 1 stores its data field. With the ready bit at 0 it stores its tag field and waits, and the slot cannot issue while any source waits.
- R4: On a clock edge where a result bus has valid high and a tag equal to a waiting source's tag, that source captures the bus data and becomes ready. This applies to any of the NBC buses, and on several buses in the same cycle. If two buses match one source, the lower-numbered bus wins.
- R5: A broadcast whose tag matches no waiting source leaves the slot unchanged. This includes a tag equal to the stored tag field of a source that is already ready.
- R6: A broadcast in the same cycle as the dispatch of a source waiting for that tag is captured at the dispatch edge.
- R7: A slot holding both operands, whose port number (binary, `disp_port`) selects a port with `port_free` high, is issued at the next edge. At that edge `iss_valid[p]` rises with the slot's op, both source values and destination tag on lane p, and the slot becomes empty. A slot dispatched at edge k issues no earlier than edge k+1.
- R8: A source woken at edge k makes its slot eligible no earlier than edge k+1, so issue outputs show it one cycle after the wake-up edge at the earliest.
- R9: Ports select independently, so up to PORTS slots issue per cycle. Among eligible slots for one port, the lowest-numbered slot wins.
- R10: While `port_free[p]` is low, nothing issues on port p and `iss_valid[p]` reads 0 on the next cycle. Eligible slots for that port stay in the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the pool and cancel issue |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | At least one slot is empty |
| disp_op | input | OP_W | Operation code |
| disp_port | input | PSEL_W | Target port number (binary) |
| disp_dst | input | TAG_W | Destination tag |
| disp_s1_rdy | input | 1 | Source 1 value present |
| disp_s1_tag | input | TAG_W | Source 1 producer tag |
| disp_s1_data | input | DATA_W | Source 1 value |
| disp_s2_rdy | input | 1 | Source 2 value present |
| disp_s2_tag | input | TAG_W | Source 2 producer tag |
| disp_s2_data | input | DATA_W | Source 2 value |
| bc_valid | input | NBC | Result bus valid, one bit per bus |
| bc_tag | input | NBC*TAG_W | Result bus tags, bus b at bits b*TAG_W |
| bc_data | input | NBC*DATA_W | Result bus values, bus b at bits b*DATA_W |
| port_free | input | PORTS | Port can accept an issue this cycle |
| iss_valid | output | PORTS | Issue lane valid |
| iss_op | output | PORTS*OP_W | Issued op per lane |
| iss_s1 | output | PORTS*DATA_W | Issued source 1 per lane |
| iss_s2 | output | PORTS*DATA_W | Issued source 2 per lane |
| iss_dst | output | PORTS*TAG_W | Issued destination tag per lane |

## Verification
The bench builds the pool with 4 slots, 2 ports, 2 result buses, 4-bit tags, 8-bit data and 4-bit ops. With only 4 slots, filling the pool and offering a dropped dispatch takes a handful of cycles. Every tag value can be swept on every bus, each with a mismatching broadcast first. The two ports make independent lowest-slot selection and a blocked port observable together. Expected lane contents come from arithmetic on the sweep index.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  parameter int RSP_ENTRIES = 20;
  parameter int RSP_PORTS   = 5;
  parameter int RSP_NBC     = 2;
  parameter int RSP_TAG_W   = 6;
  parameter int RSP_DATA_W  = 32;
  parameter int RSP_OP_W    = 8;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsp_pick_first.sv
module rsp_pick_first #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rsp_wakeup.sv
module rsp_wakeup #(
  parameter int NBC    = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                  have,
  input  logic [TAG_W-1:0]      tag,
  input  logic [NBC-1:0]        bc_valid,
  input  logic [NBC*TAG_W-1:0]  bc_tag,
  input  logic [NBC*DATA_W-1:0] bc_data,
  output logic                  hit,
  output logic [DATA_W-1:0]     data
);
  // Scan from the top bus down so the lowest-numbered match is kept.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int b = NBC - 1; b >= 0; b--) begin
      if (!have && bc_valid[b] && (bc_tag[b*TAG_W +: TAG_W] == tag)) begin
        hit  = 1'b1;
        data = bc_data[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rsp_select.sv
module rsp_select #(
  parameter int ENTRIES = 20,
  parameter int PORTS   = 5,
  parameter int PSEL_W  = 3
) (
  input  logic [ENTRIES-1:0] ready,
  input  logic [PSEL_W-1:0]  port_of [ENTRIES],
  input  logic [PORTS-1:0]   port_free,
  output logic [ENTRIES-1:0] gnt [PORTS],
  output logic [PORTS-1:0]   go
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [ENTRIES-1:0] req;

    always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
        req[i] = ready[i] && (port_of[i] == PSEL_W'(p)) && port_free[p];
      end
    end

    rsp_pick_first #(.N(ENTRIES)) u_pick (
      .req (req),
      .gnt (gnt[p]),
      .any (go[p])
    );
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rsp_pkg::*;
#(
  parameter int ENTRIES = RSP_ENTRIES,
  parameter int PORTS   = RSP_PORTS,
  parameter int NBC     = RSP_NBC,
  parameter int TAG_W   = RSP_TAG_W,
  parameter int DATA_W  = RSP_DATA_W,
  parameter int OP_W    = RSP_OP_W,
  localparam int PSEL_W = sel_width(PORTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    disp_valid,
  output logic                    disp_ready,
  input  logic [OP_W-1:0]         disp_op,
  input  logic [PSEL_W-1:0]       disp_port,
  input  logic [TAG_W-1:0]        disp_dst,
  input  logic                    disp_s1_rdy,
  input  logic [TAG_W-1:0]        disp_s1_tag,
  input  logic [DATA_W-1:0]       disp_s1_data,
  input  logic                    disp_s2_rdy,
  input  logic [TAG_W-1:0]        disp_s2_tag,
  input  logic [DATA_W-1:0]       disp_s2_data,
  input  logic [NBC-1:0]          bc_valid,
  input  logic [NBC*TAG_W-1:0]    bc_tag,
  input  logic [NBC*DATA_W-1:0]   bc_data,
  input  logic [PORTS-1:0]        port_free,
  output logic [PORTS-1:0]        iss_valid,
  output logic [PORTS*OP_W-1:0]   iss_op,
  output logic [PORTS*DATA_W-1:0] iss_s1,
  output logic [PORTS*DATA_W-1:0] iss_s2,
  output logic [PORTS*TAG_W-1:0]  iss_dst
);
  // Slot state: control bits carry reset, payload does not.
  logic [ENTRIES-1:0] e_vld;
  logic [ENTRIES-1:0] e_s1v;
  logic [ENTRIES-1:0] e_s2v;
  logic [OP_W-1:0]    e_op   [ENTRIES];
  logic [PSEL_W-1:0]  e_port [ENTRIES];
  logic [TAG_W-1:0]   e_dst  [ENTRIES];
  logic [TAG_W-1:0]   e_s1t  [ENTRIES];
  logic [TAG_W-1:0]   e_s2t  [ENTRIES];
  logic [DATA_W-1:0]  e_s1d  [ENTRIES];
  logic [DATA_W-1:0]  e_s2d  [ENTRIES];

  // Allocation
  logic [ENTRIES-1:0] free_mask;
  logic [ENTRIES-1:0] alloc_gnt;
  logic               any_free;
  logic               disp_fire;

  assign free_mask = ~e_vld;

  rsp_pick_first #(.N(ENTRIES)) u_alloc (
    .req (free_mask),
    .gnt (alloc_gnt),
    .any (any_free)
  );

  assign disp_ready = any_free;
  assign disp_fire  = disp_valid && any_free;

  // Wake-up of sources arriving with the dispatch itself
  logic              d1_hit, d2_hit;
  logic [DATA_W-1:0] d1_data, d2_data;

  rsp_wakeup #(.NBC(NBC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dw1 (
    .have (disp_s1_rdy), .tag (disp_s1_tag),
    .bc_valid (bc_valid), .bc_tag (bc_tag), .bc_data (bc_data),
    .hit (d1_hit), .data (d1_data)
  );

  rsp_wakeup #(.NBC(NBC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dw2 (
    .have (disp_s2_rdy), .tag (disp_s2_tag),
    .bc_valid (bc_valid), .bc_tag (bc_tag), .bc_data (bc_data),
    .hit (d2_hit), .data (d2_data)
  );

  // Wake-up of sources already held in the pool
  logic [ENTRIES-1:0] w1_hit, w2_hit;
  logic [DATA_W-1:0]  w1_data [ENTRIES];
  logic [DATA_W-1:0]  w2_data [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_wake
    rsp_wakeup #(.NBC(NBC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_w1 (
      .have (e_s1v[i]), .tag (e_s1t[i]),
      .bc_valid (bc_valid), .bc_tag (bc_tag), .bc_data (bc_data),
      .hit (w1_hit[i]), .data (w1_data[i])
    );
    rsp_wakeup #(.NBC(NBC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_w2 (
      .have (e_s2v[i]), .tag (e_s2t[i]),
      .bc_valid (bc_valid), .bc_tag (bc_tag), .bc_data (bc_data),
      .hit (w2_hit[i]), .data (w2_data[i])
    );
  end

  // Selection works on registered readiness only, so a wake-up at this
  // edge becomes visible to the selector one cycle later.
  logic [ENTRIES-1:0] ready;
  logic [ENTRIES-1:0] sel_gnt [PORTS];
  logic [PORTS-1:0]   sel_go;
  logic [ENTRIES-1:0] issue_mask;

  assign ready = e_vld & e_s1v & e_s2v;

  rsp_select #(.ENTRIES(ENTRIES), .PORTS(PORTS), .PSEL_W(PSEL_W)) u_sel (
    .ready     (ready),
    .port_of   (e_port),
    .port_free (port_free),
    .gnt       (sel_gnt),
    .go        (sel_go)
  );

  always_comb begin
    issue_mask = '0;
    for (int p = 0; p < PORTS; p++) issue_mask = issue_mask | sel_gnt[p];
  end

  // One-hot read of the granted slot per port
  logic [OP_W-1:0]   sel_op  [PORTS];
  logic [DATA_W-1:0] sel_s1  [PORTS];
  logic [DATA_W-1:0] sel_s2  [PORTS];
  logic [TAG_W-1:0]  sel_dst [PORTS];

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      sel_op[p]  = '0;
      sel_s1[p]  = '0;
      sel_s2[p]  = '0;
      sel_dst[p] = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (sel_gnt[p][i]) begin
          sel_op[p]  = sel_op[p]  | e_op[i];
          sel_s1[p]  = sel_s1[p]  | e_s1d[i];
          sel_s2[p]  = sel_s2[p]  | e_s2d[i];
          sel_dst[p] = sel_dst[p] | e_dst[i];
        end
      end
    end
  end

  // Control state
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      e_vld     <= '0;
      e_s1v     <= '0;
      e_s2v     <= '0;
      iss_valid <= '0;
    end else begin
      iss_valid <= sel_go;
      for (int i = 0; i < ENTRIES; i++) begin
        if (disp_fire && alloc_gnt[i]) begin
          e_vld[i] <= 1'b1;
          e_s1v[i] <= disp_s1_rdy || d1_hit;
          e_s2v[i] <= disp_s2_rdy || d2_hit;
        end else begin
          if (issue_mask[i]) e_vld[i] <= 1'b0;
          if (w1_hit[i])     e_s1v[i] <= 1'b1;
          if (w2_hit[i])     e_s2v[i] <= 1'b1;
        end
      end
    end
  end

  // Payload and issue lanes (no reset)
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (disp_fire && alloc_gnt[i]) begin
        e_op[i]   <= disp_op;
        e_port[i] <= disp_port;
        e_dst[i]  <= disp_dst;
        e_s1t[i]  <= disp_s1_tag;
        e_s2t[i]  <= disp_s2_tag;
        e_s1d[i]  <= disp_s1_rdy ? disp_s1_data : d1_data;
        e_s2d[i]  <= disp_s2_rdy ? disp_s2_data : d2_data;
      end else begin
        if (w1_hit[i]) e_s1d[i] <= w1_data[i];
        if (w2_hit[i]) e_s2d[i] <= w2_data[i];
      end
    end
    for (int p = 0; p < PORTS; p++) begin
      if (sel_go[p]) begin
        iss_op [p*OP_W   +: OP_W]   <= sel_op[p];
        iss_s1 [p*DATA_W +: DATA_W] <= sel_s1[p];
        iss_s2 [p*DATA_W +: DATA_W] <= sel_s2[p];
        iss_dst[p*TAG_W  +: TAG_W]  <= sel_dst[p];
      end
    end
  end

  // Assertions
  p_flush_empties_r1: assert property (@(posedge clk) disable iff (rst)
    flush |=> (e_vld == '0) && (iss_valid == '0));

  p_full_drops_r2: assert property (@(posedge clk) disable iff (rst || flush)
    (disp_valid && !disp_ready) |=> ($countones(e_vld) <= $past($countones(e_vld))));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk_entry
    p_operands_before_issue_r8: assert property (@(posedge clk) disable iff (rst)
      ($fell(e_vld[i]) && !$past(flush)) |-> $past(e_s1v[i] && e_s2v[i]));

    p_held_value_stable_r5: assert property (@(posedge clk) disable iff (rst || flush)
      ($past(e_vld[i] && e_s1v[i]) && e_vld[i]) |-> $stable(e_s1d[i]));
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_chk_port
    p_busy_port_idle_r10: assert property (@(posedge clk) disable iff (rst)
      iss_valid[p] |-> $past(port_free[p]));
  end
endmodule

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int PORTS   = 2;
  localparam int NBC     = 2;
  localparam int TAG_W   = 4;
  localparam int DATA_W  = 8;
  localparam int OP_W    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic disp_valid = 1'b0;
  logic disp_ready;
  logic [OP_W-1:0] disp_op = '0;
  logic [0:0] disp_port = '0;
  logic [TAG_W-1:0] disp_dst = '0;
  logic disp_s1_rdy = 1'b0;
  logic [TAG_W-1:0] disp_s1_tag = '0;
  logic [DATA_W-1:0] disp_s1_data = '0;
  logic disp_s2_rdy = 1'b0;
  logic [TAG_W-1:0] disp_s2_tag = '0;
  logic [DATA_W-1:0] disp_s2_data = '0;
  logic [NBC-1:0] bc_valid = '0;
  logic [NBC*TAG_W-1:0] bc_tag = '0;
  logic [NBC*DATA_W-1:0] bc_data = '0;
  logic [PORTS-1:0] port_free = '0;
  logic [PORTS-1:0] iss_valid;
  logic [PORTS*OP_W-1:0] iss_op;
  logic [PORTS*DATA_W-1:0] iss_s1;
  logic [PORTS*DATA_W-1:0] iss_s2;
  logic [PORTS*TAG_W-1:0] iss_dst;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_pool #(.ENTRIES(ENTRIES), .PORTS(PORTS), .NBC(NBC), .TAG_W(TAG_W),
            .DATA_W(DATA_W), .OP_W(OP_W)) u0 (
    .clk, .rst, .flush, .disp_valid, .disp_ready, .disp_op, .disp_port,
    .disp_dst, .disp_s1_rdy, .disp_s1_tag, .disp_s1_data, .disp_s2_rdy,
    .disp_s2_tag, .disp_s2_data, .bc_valid, .bc_tag, .bc_data, .port_free,
    .iss_valid, .iss_op, .iss_s1, .iss_s2, .iss_dst
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic disp(input int op, input int port, input bit r1, input int v1,
                      input bit r2, input int v2, input int dst);
    disp_valid   = 1'b1;
    disp_op      = OP_W'(op);
    disp_port    = 1'(port);
    disp_dst     = TAG_W'(dst);
    disp_s1_rdy  = r1;
    disp_s1_tag  = TAG_W'(v1);
    disp_s1_data = DATA_W'(v1);
    disp_s2_rdy  = r2;
    disp_s2_tag  = TAG_W'(v2);
    disp_s2_data = DATA_W'(v2);
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic set_bc(input int b, input int tag, input int data);
    bc_valid[b] = 1'b1;
    bc_tag[b*TAG_W +: TAG_W] = TAG_W'(tag);
    bc_data[b*DATA_W +: DATA_W] = DATA_W'(data);
  endtask

  task automatic exp_lane(input string req, input int p, input bit v,
                          input int op, input int s1, input int s2, input int dst);
    chk_eq(req, $sformatf("iss_valid[%0d]", p), int'(iss_valid[p]), int'(v));
    if (v) begin
      chk_eq(req, "iss_op",  int'(iss_op [p*OP_W   +: OP_W]),   op);
      chk_eq(req, "iss_s1",  int'(iss_s1 [p*DATA_W +: DATA_W]), s1);
      chk_eq(req, "iss_s2",  int'(iss_s2 [p*DATA_W +: DATA_W]), s2);
      chk_eq(req, "iss_dst", int'(iss_dst[p*TAG_W  +: TAG_W]),  dst);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_eq("R1", "disp_ready", int'(disp_ready), 1);
    chk_eq("R1", "iss_valid", int'(iss_valid), 0);

    // R7 simple issue path
    port_free = 2'b11;
    disp(1, 0, 1, 8'h11, 1, 8'h22, 3);
    exp_lane("R7", 0, 0, 0, 0, 0, 0);
    tick();
    exp_lane("R7", 0, 1, 1, 8'h11, 8'h22, 3);
    tick();
    exp_lane("R7", 0, 0, 0, 0, 0, 0);

    // R2 / R9 fill, drop extra, then drain in slot order
    port_free = 2'b00;
    for (int k = 1; k <= 4; k++) disp(k, 0, 1, k * 16, 1, k + 1, k);
    chk_eq("R2", "disp_ready full", int'(disp_ready), 0);
    disp(7, 0, 1, 8'h70, 1, 8'h71, 7);
    port_free = 2'b01;
    for (int k = 1; k <= 4; k++) begin
      tick();
      exp_lane("R9", 0, 1, k, k * 16, k + 1, k);
    end
    tick();
    exp_lane("R2", 0, 0, 0, 0, 0, 0);
    chk_eq("R2", "disp_ready drained", int'(disp_ready), 1);

    // R9 independent ports
    port_free = 2'b00;
    disp(5, 1, 1, 5, 1, 5, 5);
    disp(6, 0, 1, 6, 1, 6, 6);
    disp(7, 1, 1, 7, 1, 7, 7);
    port_free = 2'b11;
    tick();
    exp_lane("R9", 0, 1, 6, 6, 6, 6);
    exp_lane("R9", 1, 1, 5, 5, 5, 5);
    tick();
    exp_lane("R9", 0, 0, 0, 0, 0, 0);
    exp_lane("R9", 1, 1, 7, 7, 7, 7);
    tick();
    exp_lane("R9", 1, 0, 0, 0, 0, 0);

    // R10 blocked port
    port_free = 2'b01;
    disp(8, 1, 1, 8, 1, 9, 8);
    for (int k = 0; k < 3; k++) begin
      tick();
      exp_lane("R10", 1, 0, 0, 0, 0, 0);
    end
    port_free = 2'b11;
    tick();
    exp_lane("R10", 1, 1, 8, 8, 9, 8);
    tick();

    // R3 / R4 / R5 / R8 sweep of every tag on every bus
    for (int t = 0; t < 16; t++) begin
      for (int b = 0; b < NBC; b++) begin
        disp(t, 0, 0, t, 1, 8'h5A, t);
        exp_lane("R3", 0, 0, 0, 0, 0, 0);
        set_bc(b, t ^ 1, 8'hEE);
        tick();
        bc_valid = '0;
        tick();
        exp_lane("R5", 0, 0, 0, 0, 0, 0);
        set_bc(b, t, t * 7 + b + 1);
        tick();
        bc_valid = '0;
        exp_lane("R8", 0, 0, 0, 0, 0, 0);
        tick();
        exp_lane("R4", 0, 1, t, (t * 7 + b + 1) & 8'hFF, 8'h5A, t);
      end
    end

    // R5 a ready source ignores a broadcast of its stored tag field
    port_free = 2'b00;
    disp(9, 0, 1, 8'h13, 0, 4, 9);
    set_bc(0, 3, 8'h99);
    set_bc(1, 4, 8'h44);
    tick();
    bc_valid = '0;
    port_free = 2'b01;
    tick();
    exp_lane("R5", 0, 1, 9, 8'h13, 8'h44, 9);

    // R6 capture in the dispatch cycle
    port_free = 2'b11;
    set_bc(1, 9, 8'h77);
    disp(10, 0, 0, 9, 1, 8'h01, 2);
    bc_valid = '0;
    exp_lane("R6", 0, 0, 0, 0, 0, 0);
    tick();
    exp_lane("R6", 0, 1, 10, 8'h77, 8'h01, 2);

    // R4 both sources woken on two buses at once, and bus priority
    disp(11, 1, 0, 2, 0, 6, 4);
    set_bc(0, 2, 8'h12);
    set_bc(1, 6, 8'h16);
    tick();
    bc_valid = '0;
    tick();
    exp_lane("R4", 1, 1, 11, 8'h12, 8'h16, 4);
    disp(12, 1, 0, 5, 1, 8'h02, 5);
    set_bc(0, 5, 8'hA0);
    set_bc(1, 5, 8'hB1);
    tick();
    bc_valid = '0;
    tick();
    exp_lane("R4", 1, 1, 12, 8'hA0, 8'h02, 5);

    // R1 flush
    port_free = 2'b00;
    for (int k = 0; k < 3; k++) disp(13, 0, 1, k, 1, k, k);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk_eq("R1", "disp_ready after flush", int'(disp_ready), 1);
    chk_eq("R1", "iss_valid after flush", int'(iss_valid), 0);
    port_free = 2'b11;
    tick();
    tick();
    chk_eq("R1", "no issue after flush", int'(iss_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule